// File: doc/BRIEF.md
# Dual-Output Serial Flash Burst Reader

This block sits on the host side of a serial flash device and fetches a run of consecutive bytes with a single command. A caller presents a 24-bit start address, a byte count and a read mode, then pulses a start strobe. The block lowers chip select and clocks out an 8-bit command code and the address. For the two fast modes it then runs eight idle clocks. After that it gathers read data from the device and hands each finished byte to a valid/ready output stream.

There are three read modes. The plain read has no idle clocks and uses one return wire. The fast read adds eight idle clocks and still uses one return wire. The dual read adds eight idle clocks and then takes data on two wires, so each byte needs only four serial clocks. The serial clock is made from the system clock by a divider that the caller sets. Between commands, chip select stays high for a minimum time.

The output stream follows the usual valid/ready rules. A byte that has been offered stays on the output, unchanged, until the consumer accepts it. If the consumer stalls, the block parks the serial clock low just before the rising edge that would complete the next byte. No byte is ever dropped or overwritten, and the device never sees a clock it cannot answer.

Top module: `flash_burst_reader`

## Requirements
- R1: The command code is 8'h03 when req_mode is 2'b00, 8'h0B when req_mode is 2'b01, and 8'h3B when req_mode[1] is 1. It goes out on spi_si_o most significant bit first, followed by the 24-bit address most significant bit first. Each bit is stable across the rising edge of spi_sck.
- R2: In both fast modes, exactly eight spi_sck rising edges lie between the last address bit and the first data bit. In the plain mode the first data bit is sampled on the rising edge right after the last address bit.
- R3: In single-wire modes, read data is sampled from spi_so_i on rising edges of spi_sck, bit 7 first, eight clocks per byte. In dual mode each byte takes four clocks: spi_so_i carries bits 7,5,3,1 and spi_si_i carries bits 6,4,2,0, each pair sampled together on a rising edge.
- R4: A start with req_len nonzero yields exactly req_len bytes, from the start address upward, with the address wrapping modulo 2^24. spi_cs_n rises at the falling edge of spi_sck that follows the final capture. A start with req_len equal to 0 is ignored.
- R5: spi_sck is low whenever spi_cs_n is high. spi_cs_n stays high for at least two system clocks between commands.
- R6: While m_valid is high and m_ready is low, m_valid stays high and m_data stays unchanged. A stalled consumer stops spi_sck, and no byte is lost.
- R7: Each high phase of spi_sck lasts cfg_div/2 system clocks, rounded down and never less than 1. The divider value is captured when a start is accepted.
- R8: busy goes high on the clock after a start is accepted and stays high until the chip-select gap has elapsed. A start that arrives while busy is ignored.
- R9: spi_si_oe is high during the command, address and idle clocks. It is low throughout the data phase, so the device can drive spi_si_i.
- R10: After reset, spi_cs_n is 1, spi_sck is 0, busy is 0 and m_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | Serial clock divide ratio (even, 2 or more) |
| req_start | input | 1 | Start strobe, taken when idle |
| req_mode | input | 2 | 00 plain, 01 fast single, 1x fast dual |
| req_addr | input | 24 | First byte address |
| req_len | input | LEN_W | Number of bytes to read |
| busy | output | 1 | A command is in progress |
| spi_cs_n | output | 1 | Device select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_si_o | output | 1 | Command and address bit toward the device |
| spi_si_oe | output | 1 | Drive enable for spi_si_o |
| spi_si_i | input | 1 | Shared line read back (even bits in dual mode) |
| spi_so_i | input | 1 | Device data output (odd bits in dual mode) |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Consumer accepts the byte |
| m_data | output | 8 | Assembled byte |

## Verification
A wrong bit or phase counter mostly shows up as byte corruption rather than a hang. A command bit off by one makes the device model return data from the wrong address, and a wrong idle-clock count or pin-to-bit mapping makes the very first streamed byte of a transfer differ from the expected value. A wrong stall condition either loses a byte, which shows up as a count shortfall once busy falls, or changes m_data while it is held, which is visible on the next cycle. A wrong divider or gap counter shows up as a wrong spi_sck high-time, or a wrong chip-select high-time, within the first serial clock of a transfer.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DUMMY,
    ST_DATA,
    ST_GAP
  } rd_state_e;

  localparam logic [7:0] OPC_PLAIN = 8'h03;
  localparam logic [7:0] OPC_FAST  = 8'h0B;
  localparam logic [7:0] OPC_DUAL  = 8'h3B;

  localparam int ADDR_W     = 24;
  localparam int OPC_W      = 8;
  localparam int DUMMY_CLKS = 8;

  function automatic logic [7:0] opcode_for(input logic [1:0] mode);
    if (mode[1])      return OPC_DUAL;
    else if (mode[0]) return OPC_FAST;
    else              return OPC_PLAIN;
  endfunction

endpackage

// File: rtl/fbr_sck_gen.sv
module fbr_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] half,
  output logic             sck,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             parked;
  logic             tick;

  assign parked = hold && !sck;
  assign tick   = run && !parked && (cnt == half - DIV_W'(1));
  assign rise   = tick && !sck;
  assign fall   = tick && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (parked) begin
      cnt <= cnt;
    end else if (tick) begin
      cnt <= '0;
      sck <= !sck;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/fbr_rx_deser.sv
module fbr_rx_deser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift,
  input  logic              dual,
  input  logic              so_i,
  input  logic              si_i,
  output logic [BYTE_W-1:0] next_byte
);
  logic [BYTE_W-1:0] acc;

  always_comb begin
    if (dual) next_byte = {acc[BYTE_W-3:0], so_i, si_i};
    else      next_byte = {acc[BYTE_W-2:0], so_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clr)   acc <= '0;
    else if (shift) acc <= next_byte;
  end
endmodule

// File: rtl/flash_burst_reader.sv
module flash_burst_reader
  import fbr_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int LEN_W    = 16,
  parameter int GAP_CLKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     cfg_div,
  input  logic                 req_start,
  input  logic [1:0]           req_mode,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LEN_W-1:0]     req_len,
  output logic                 busy,
  output logic                 spi_cs_n,
  output logic                 spi_sck,
  output logic                 spi_si_o,
  output logic                 spi_si_oe,
  input  logic                 spi_si_i,
  input  logic                 spi_so_i,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [7:0]           m_data
);
  localparam int CMD_BITS = OPC_W + ADDR_W;
  localparam int CNT_W    = $clog2(CMD_BITS);
  localparam int GAP_W    = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;

  rd_state_e             state;
  logic [CMD_BITS-1:0]   cmd_sr;
  logic [CNT_W-1:0]      cnt;
  logic [LEN_W-1:0]      left;
  logic                  dual_q;
  logic                  fast_q;
  logic                  last_q;
  logic [DIV_W-1:0]      half_q;
  logic [DIV_W-1:0]      half_new;
  logic [GAP_W-1:0]      gap_cnt;
  logic                  cs_n_q;
  logic                  run;
  logic                  sck_hold;
  logic                  sck_rise;
  logic                  sck_fall;
  logic                  bit_last;
  logic                  push;
  logic [7:0]            rx_byte;

  assign half_new = ((cfg_div >> 1) == '0) ? DIV_W'(1) : (cfg_div >> 1);
  assign run      = (state == ST_CMD) || (state == ST_DUMMY) || (state == ST_DATA);
  assign bit_last = dual_q ? (cnt == CNT_W'(3)) : (cnt == CNT_W'(7));
  assign sck_hold = (state == ST_DATA) && bit_last && m_valid && !m_ready;
  assign push     = (state == ST_DATA) && sck_rise && bit_last;

  fbr_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .hold (sck_hold),
    .half (half_q),
    .sck  (spi_sck),
    .rise (sck_rise),
    .fall (sck_fall)
  );

  fbr_rx_deser #(.BYTE_W(8)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (state == ST_IDLE),
    .shift    ((state == ST_DATA) && sck_rise),
    .dual     (dual_q),
    .so_i     (spi_so_i),
    .si_i     (spi_si_i),
    .next_byte(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cmd_sr  <= '0;
      cnt     <= '0;
      left    <= '0;
      dual_q  <= 1'b0;
      fast_q  <= 1'b0;
      last_q  <= 1'b0;
      half_q  <= DIV_W'(1);
      gap_cnt <= '0;
      cs_n_q  <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_start && (req_len != '0)) begin
            state  <= ST_CMD;
            cmd_sr <= {opcode_for(req_mode), req_addr};
            cnt    <= '0;
            left   <= req_len;
            dual_q <= req_mode[1];
            fast_q <= req_mode[0] | req_mode[1];
            last_q <= 1'b0;
            half_q <= half_new;
            cs_n_q <= 1'b0;
          end
        end
        ST_CMD: begin
          if (sck_fall) begin
            cmd_sr <= cmd_sr << 1;
            if (cnt == CNT_W'(CMD_BITS - 1)) begin
              cnt   <= '0;
              state <= fast_q ? ST_DUMMY : ST_DATA;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        ST_DUMMY: begin
          if (sck_fall) begin
            if (cnt == CNT_W'(DUMMY_CLKS - 1)) begin
              cnt   <= '0;
              state <= ST_DATA;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        ST_DATA: begin
          if (sck_rise) begin
            if (bit_last) begin
              cnt  <= '0;
              left <= left - LEN_W'(1);
              if (left == LEN_W'(1)) last_q <= 1'b1;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end else if (sck_fall && last_q) begin
            state   <= ST_GAP;
            gap_cnt <= '0;
            cs_n_q  <= 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_cnt == GAP_W'(GAP_CLKS - 1)) state <= ST_IDLE;
          else gap_cnt <= gap_cnt + GAP_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (push) begin
      m_valid <= 1'b1;
      m_data  <= rx_byte;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign spi_cs_n  = cs_n_q;
  assign spi_si_o  = cmd_sr[CMD_BITS-1];
  assign spi_si_oe = (state == ST_CMD) || (state == ST_DUMMY);

endmodule

// File: rtl/fbr_chk.sv
module fbr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       cs_n,
  input logic       sck,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       hold
);
  AST_SCK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck); // R5

  AST_CS_HIGH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n); // R8

  AST_STREAM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R6

  AST_CS_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n); // R5

  AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !sck) |=> !sck); // R6
endmodule

bind flash_burst_reader fbr_chk u_fbr_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .cs_n   (spi_cs_n),
  .sck    (spi_sck),
  .m_valid(m_valid),
  .m_ready(m_ready),
  .m_data (m_data),
  .hold   (sck_hold)
);

// File: tb/tb_flash_burst_reader.sv
`timescale 1ns/1ps
module tb_flash_burst_reader;
  localparam int DIV_W = 8;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] cfg_div = 8'd2;
  logic             req_start = 1'b0;
  logic [1:0]       req_mode = 2'b00;
  logic [23:0]      req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             busy, spi_cs_n, spi_sck, spi_si_o, spi_si_oe;
  logic             spi_si_i, spi_so_i;
  logic             m_valid, m_ready;
  logic [7:0]       m_data;

  logic dev_so = 1'b0, dev_si = 1'b0, dev_si_en = 1'b0;
  assign spi_so_i = dev_so;
  assign spi_si_i = dev_si_en ? dev_si : spi_si_o;

  always #4 clk = !clk;

  flash_burst_reader #(.DIV_W(DIV_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .req_start(req_start),
    .req_mode(req_mode), .req_addr(req_addr), .req_len(req_len), .busy(busy),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_si_o(spi_si_o),
    .spi_si_oe(spi_si_oe), .spi_si_i(spi_si_i), .spi_so_i(spi_so_i),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'hA5;
  endfunction

  function automatic logic [7:0] opc_of(input logic [1:0] m);
    if (m[1]) return 8'h3B;
    if (m[0]) return 8'h0B;
    return 8'h03;
  endfunction

  // expected stream and request bookkeeping
  logic [7:0]  exp_q[$];
  logic [31:0] exp_cmd;
  int          exp_half;
  int          ready_pct = 100;

  // ---------------- device model ----------------
  int          nr;
  int          dmy;
  bit          dual_rd;
  bit          first_hi;
  logic [31:0] rx_cmd;
  longint      t_rise;
  longint      t_cs_up = -1;

  always @(negedge spi_cs_n) begin
    nr = 0; rx_cmd = '0; dmy = 0; dual_rd = 0; first_hi = 1; dev_si_en = 0;
    if (t_cs_up >= 0)
      chk(($time - t_cs_up) >= 16, "R5 cs high time", $time - t_cs_up, 16);
  end

  always @(posedge spi_cs_n) begin
    dev_si_en = 0;
    t_cs_up = $time;
  end

  always @(posedge spi_sck) begin
    t_rise = $time;
    if (spi_cs_n) chk(0, "R5 sck high while deselected", 1, 0);
    else begin
      if (nr < 32) rx_cmd = {rx_cmd[30:0], spi_si_o};
      if (nr < 32 + dmy) chk(spi_si_oe == 1'b1, "R9 host drives in cmd/dummy", spi_si_oe, 1);
      else chk(spi_si_oe == 1'b0, "R9 host released in data", spi_si_oe, 0);
      nr++;
      if (nr == 32) begin
        chk(rx_cmd == exp_cmd, "R1 opcode+address", rx_cmd, exp_cmd);
        dual_rd = (rx_cmd[31:24] == 8'h3B);
        dmy = (rx_cmd[31:24] == 8'h03) ? 0 : 8;
      end
    end
  end

  always @(negedge spi_sck) begin
    if (first_hi) begin
      first_hi = 0;
      chk(($time - t_rise) == longint'(exp_half) * 8, "R7 sck high phase",
          ($time - t_rise) / 8, exp_half);
    end
    if (!spi_cs_n && nr >= 32 + dmy) begin
      int k; logic [7:0] b; logic [23:0] a;
      k = nr - 32 - dmy;
      a = rx_cmd[23:0];
      if (dual_rd) begin
        a = a + 24'(k / 4);
        b = mem_byte(a);
        dev_so = b[7 - 2 * (k % 4)];
        dev_si = b[6 - 2 * (k % 4)];
        dev_si_en = 1;
      end else begin
        a = a + 24'(k / 8);
        b = mem_byte(a);
        dev_so = b[7 - (k % 8)];
      end
    end
  end

  // ---------------- consumer ----------------
  initial m_ready = 1'b1;
  always @(negedge clk) begin
    m_ready <= (($urandom % 100) < ready_pct);
    #1;
    if (rst_n && m_valid && m_ready) begin
      if (exp_q.size() == 0) chk(0, "R4 extra byte", m_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(m_data == e, "R3 byte value", m_data, e);
      end
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run_req(input logic [1:0] m, input logic [23:0] a,
                         input int len, input logic [7:0] div);
    int waited;
    @(negedge clk);
    cfg_div  = div;
    req_mode = m;
    req_addr = a;
    req_len  = LEN_W'(len);
    exp_cmd  = {opc_of(m), a};
    exp_half = ((div >> 1) == 0) ? 1 : int'(div >> 1);
    for (int i = 0; i < len; i++) exp_q.push_back(mem_byte(a + 24'(i)));
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    // a second start while busy must be ignored
    repeat (3) @(negedge clk);
    req_addr = a ^ 24'h00F0F0;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    waited = 0;
    while ((busy || exp_q.size() != 0) && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    chk(exp_q.size() == 0, "R4 byte count / R6 no loss", exp_q.size(), 0);
    chk(spi_cs_n == 1'b1, "R4 deselect at end", spi_cs_n, 1);
    exp_q.delete();
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R10 reset cs_n", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R10 reset sck", spi_sck, 0);
    chk(busy == 1'b0, "R10 reset busy", busy, 0);
    chk(m_valid == 1'b0, "R10 reset m_valid", m_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4: zero length ignored
    req_len = '0; req_start = 1'b1;
    @(negedge clk); req_start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R4 zero length ignored busy", busy, 0);
    chk(spi_cs_n == 1'b1, "R4 zero length ignored cs", spi_cs_n, 1);

    // directed corners
    run_req(2'b00, 24'h012345, 3, 8'd2);      // R2 plain, no dummy
    run_req(2'b01, 24'h00ABCD, 5, 8'd4);      // R2 fast single
    run_req(2'b10, 24'h100000, 8, 8'd2);      // R3 dual
    run_req(2'b11, 24'hFFFFFE, 4, 8'd6);      // R4 address wrap, dual
    run_req(2'b10, 24'h000010, 1, 8'd0);      // R7 divide minimum
    run_req(2'b01, 24'h777777, 2, 8'd5);      // R7 odd divide rounds down
    ready_pct = 10;                            // R6 heavy back-pressure
    run_req(2'b10, 24'h2468AC, 10, 8'd2);
    run_req(2'b00, 24'h13579B, 6, 8'd4);
    ready_pct = 100;

    for (int t = 0; t < 20; t++) begin
      logic [7:0] d;
      ready_pct = 20 + int'($urandom % 81);
      d = 8'(2 * (1 + ($urandom % 4)));
      run_req(2'($urandom % 4), 24'($urandom), 1 + int'($urandom % 12), d);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule